// File: doc/BRIEF.md
# Channel Handshake Semaphore

This block keeps the handshake state of a set of message channels shared between a master processor and a slave processor. Each channel has a 2-bit state. All states are packed into one status word. Software on either side reads that word to learn where each channel stands in the request/response exchange.

Software never writes the status word directly. It writes a mask to a set offset, which turns on the masked bits. It writes a mask to a clear offset, which turns off the masked bits. Each side can therefore move its own channel without a read-modify-write and without disturbing channels that the other side is changing.

Two notification outputs pulse for one cycle. The slave-side pulse fires when a channel enters the request-pending state. The master-side pulse fires when a channel enters the response-ready state.

Top module: `chan_sema`

## Requirements
- R1: After reset, every channel field holds 2 (free), so the status word reads 0xAAAAAAAA with the default 16 channels, and both notification outputs are low.
- R2: A read at offset 0x0 returns the status word. A read at any other offset, including 0x4 and 0x8, returns zero.
- R3: A write at offset 0x4 ORs the write data into the status word. Bits written as 0 keep their value.
- R4: A write at offset 0x8 clears every status bit that is 1 in the write data. Bits written as 0 keep their value.
- R5: A write at offset 0x0, or at any offset other than 0x4 and 0x8, leaves the status word unchanged.
- R6: Channel n occupies status bits [2n+1:2n]. A write whose mask covers only channel n leaves every other channel's field unchanged.
- R7: When a write moves at least one channel from a nonzero state into state 0 (request pending), slaveNotify is high for exactly the one cycle after that write's clock edge. A write that leaves a channel already in state 0 in that state does not raise slaveNotify.
- R8: When a write moves at least one channel from a state other than 3 into state 3 (response ready), masterNotify is high for exactly the one cycle after that write's clock edge. A write that leaves a channel already in state 3 in that state does not raise masterNotify.
- R9: A channel is driven through its handshake by four writes, giving the sequence 2, 0, 1, 3, 2:
  - clearing both of its bits gives state 0 (request posted);
  - setting its low bit gives state 1 (response queued);
  - setting both of its bits gives state 3 (response posted);
  - clearing its low bit gives state 2 (response acknowledged, free).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register byte offset |
| regWe | input | 1 | Write strobe for the addressed register |
| regWdata | input | 32 | Write data (set or clear mask) |
| regRdata | output | 32 | Read data, combinational from regAddr |
| slaveNotify | output | 1 | One-cycle pulse: a channel entered state 0 |
| masterNotify | output | 1 | One-cycle pulse: a channel entered state 3 |

## Verification
The hardest situation to reach is a write that touches a channel which is already in the target state. In that case the notification must stay low even though the same mask raised it one write earlier. The bench repeats identical multi-channel set and clear masks back to back and checks that only the first one pulses. It also walks all sixteen channels one at a time through the complete handshake while comparing the whole status word after each step, so any disturbance of a neighbouring field shows up.

// File: rtl/chsema_pkg.sv
package chsema_pkg;
  localparam int FIELD_W = 2;

  typedef enum logic [1:0] {
    ST_REQ_POSTED = 2'd0,
    ST_RSP_QUEUED = 2'd1,
    ST_IDLE       = 2'd2,
    ST_RSP_READY  = 2'd3
  } chan_state_e;

  typedef struct packed {
    logic setWr;
    logic clrWr;
    logic statRd;
  } strobe_t;
endpackage

// File: rtl/chsema_ctrl.sv
module chsema_ctrl
  import chsema_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(8);

  always_comb begin
    stb.setWr  = regWe && (regAddr == OFF_SET);
    stb.clrWr  = regWe && (regAddr == OFF_CLR);
    stb.statRd = (regAddr == OFF_STAT);
  end
endmodule

// File: rtl/chsema_dp.sv
module chsema_dp
  import chsema_pkg::*;
#(
  parameter int CHANS = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [CHANS*FIELD_W-1:0]  regWdata,
  output logic [CHANS*FIELD_W-1:0]  statWord,
  output logic [CHANS*FIELD_W-1:0]  rdData,
  output logic                      slaveNotify,
  output logic                      masterNotify
);
  localparam int WORD_W = CHANS * FIELD_W;
  localparam logic [WORD_W-1:0] RST_WORD = {CHANS{ST_IDLE}};

  logic [WORD_W-1:0] statQ;
  logic [WORD_W-1:0] statNext;
  logic [CHANS-1:0]  enterReq;
  logic [CHANS-1:0]  enterRdy;
  logic              slvQ;
  logic              mstQ;

  always_comb begin
    statNext = statQ;
    if (stb.setWr) statNext = statNext | regWdata;
    if (stb.clrWr) statNext = statNext & ~regWdata;
  end

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
    logic [FIELD_W-1:0] curF;
    logic [FIELD_W-1:0] nxtF;
    assign curF = statQ[ch*FIELD_W +: FIELD_W];
    assign nxtF = statNext[ch*FIELD_W +: FIELD_W];
    assign enterReq[ch] = (nxtF == ST_REQ_POSTED) && (curF != ST_REQ_POSTED);
    assign enterRdy[ch] = (nxtF == ST_RSP_READY) && (curF != ST_RSP_READY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= RST_WORD;
      slvQ  <= 1'b0;
      mstQ  <= 1'b0;
    end else begin
      statQ <= statNext;
      slvQ  <= |enterReq;
      mstQ  <= |enterRdy;
    end
  end

  assign statWord     = statQ;
  assign rdData       = stb.statRd ? statQ : '0;
  assign slaveNotify  = slvQ;
  assign masterNotify = mstQ;
endmodule

// File: rtl/chan_sema.sv
module chan_sema
  import chsema_pkg::*;
#(
  parameter int CHANS  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWe,
  input  logic [CHANS*FIELD_W-1:0] regWdata,
  output logic [CHANS*FIELD_W-1:0] regRdata,
  output logic                     slaveNotify,
  output logic                     masterNotify
);
  strobe_t stb;
  logic [CHANS*FIELD_W-1:0] statWord;

  chsema_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .stb     (stb)
  );

  chsema_dp #(.CHANS(CHANS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .regWdata     (regWdata),
    .statWord     (statWord),
    .rdData       (regRdata),
    .slaveNotify  (slaveNotify),
    .masterNotify (masterNotify)
  );
endmodule

// File: rtl/chsema_chk.sv
module chsema_chk #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [WORD_W-1:0] regWdata,
  input logic [WORD_W-1:0] regRdata,
  input logic              slaveNotify,
  input logic              masterNotify,
  input logic [WORD_W-1:0] statWord
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(8);

  // R2
  rd_unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != '0) |-> (regRdata == '0));

  // R3
  set_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_SET) |=> ((statWord & $past(regWdata)) == $past(regWdata)));

  // R4
  clr_andn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_CLR) |=> ((statWord & $past(regWdata)) == '0));

  // R5
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && (regAddr == A_SET || regAddr == A_CLR)) |=> $stable(statWord));

  // R7
  slave_pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    slaveNotify |-> $past(regWe && regAddr == A_CLR));

  // R8
  master_pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    masterNotify |-> $past(regWe && regAddr == A_SET));
endmodule

bind chan_sema chsema_chk #(.ADDR_W(ADDR_W), .WORD_W(CHANS*2)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regAddr      (regAddr),
  .regWe        (regWe),
  .regWdata     (regWdata),
  .regRdata     (regRdata),
  .slaveNotify  (slaveNotify),
  .masterNotify (masterNotify),
  .statWord     (statWord)
);

// File: tb/chan_sema_test.sv
`timescale 1ns/1ps
module chan_sema_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        slaveNotify;
  logic        masterNotify;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chan_sema uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata),
    .slaveNotify(slaveNotify), .masterNotify(masterNotify)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge; return at the next falling edge with the write applied.
  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regAddr = 4'h0; regWdata = '0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
    regAddr = 4'h0;
    #1;
  endtask

  task automatic testReset();
    logic [31:0] v;
    rdReg(4'h0, v);
    chk(v, 32'hAAAAAAAA, "R1 reset status");
    chk({31'd0, slaveNotify}, 0, "R1 reset slaveNotify");
    chk({31'd0, masterNotify}, 0, "R1 reset masterNotify");
  endtask

  task automatic testHandshake();
    logic [31:0] v;
    for (int ch = 0; ch < 16; ch++) begin
      logic [31:0] m;
      logic [31:0] lo;
      logic [31:0] others;
      m = 32'h3 << (2 * ch);
      lo = 32'h1 << (2 * ch);
      others = 32'hAAAAAAAA & ~m;
      wrReg(4'h8, m);
      chk({31'd0, slaveNotify}, 1, "R7 slave pulse on post");
      rdReg(4'h0, v);
      chk(v, others, "R9 R6 post gives state 0");
      wrReg(4'h4, lo);
      chk({30'd0, slaveNotify, masterNotify}, 0, "R7 R8 no pulse on queue");
      rdReg(4'h0, v);
      chk(v, others | lo, "R9 R6 queue gives state 1");
      wrReg(4'h4, m);
      chk({31'd0, masterNotify}, 1, "R8 master pulse on response");
      rdReg(4'h0, v);
      chk(v, others | m, "R9 R6 response gives state 3");
      @(negedge clk);
      chk({31'd0, masterNotify}, 0, "R8 pulse lasts one cycle");
      wrReg(4'h8, lo);
      rdReg(4'h0, v);
      chk(v, 32'hAAAAAAAA, "R9 R6 ack gives state 2");
    end
  endtask

  task automatic testMasks();
    logic [31:0] v;
    wrReg(4'h4, 32'h0000FFFF);
    chk({31'd0, masterNotify}, 1, "R8 multi-channel set pulse");
    rdReg(4'h0, v);
    chk(v, 32'hAAAAFFFF, "R3 set ORs");
    wrReg(4'h8, 32'hFFFF0000);
    chk({31'd0, slaveNotify}, 1, "R7 multi-channel clear pulse");
    rdReg(4'h0, v);
    chk(v, 32'h0000FFFF, "R4 clear removes bits");
    @(negedge clk);
    chk({31'd0, slaveNotify}, 0, "R7 pulse lasts one cycle");
    wrReg(4'h8, 32'hFFFF0000);
    chk({31'd0, slaveNotify}, 0, "R7 no pulse when already 0");
    wrReg(4'h4, 32'h0000FFFF);
    chk({31'd0, masterNotify}, 0, "R8 no pulse when already 3");
    wrReg(4'h4, 32'h00000000);
    rdReg(4'h0, v);
    chk(v, 32'h0000FFFF, "R3 zero set mask no change");
    wrReg(4'h8, 32'h00000000);
    rdReg(4'h0, v);
    chk(v, 32'h0000FFFF, "R4 zero clear mask no change");
  endtask

  task automatic testIgnored();
    logic [31:0] v;
    wrReg(4'h0, 32'h00000000);
    wrReg(4'hC, 32'hFFFFFFFF);
    wrReg(4'h2, 32'hFFFFFFFF);
    rdReg(4'h0, v);
    chk(v, 32'h0000FFFF, "R5 stray writes ignored");
    rdReg(4'h4, v);
    chk(v, 32'h0, "R2 set offset reads zero");
    rdReg(4'h8, v);
    chk(v, 32'h0, "R2 clear offset reads zero");
    rdReg(4'hC, v);
    chk(v, 32'h0, "R2 unmapped reads zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHandshake();
    testMasks();
    testIgnored();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule